// File: doc/BRIEF.md
# Two-Wire Master Command Sequencer

This block sits between a transmit queue and a byte-level two-wire bus engine. It reads queue entries that are one byte wide plus two flag bits. Each entry becomes a bus operation: a start condition followed by an address byte, a data byte to write, or a run of bytes to read. A flag can also request a stop condition once the entry's byte is done. Timing on the wires themselves, and clock stretching, belong to the bus engine. The sequencer only issues one command at a time and waits for the engine's completion pulse. With that pulse, the engine returns the slave's acknowledge or the byte it read.

Software or a neighbouring controller loads the queue and then watches two event pulses. The error pulse reports a refused address or data byte, and it also marks the end of a read, because the final byte read is deliberately not acknowledged. The idle pulse reports that a stop has finished and the bus has been released. After a refused byte, the sequencer releases the bus and throws away the queue entries left over from the failed transfer. Read data leaves the block as one push per byte.

Top module: `tw_cmd_seq`

## Requirements
- R1: After reset, phy_req, bus_busy, tx_err, bus_idle_evt and rx_push are all 0.
- R2: When enable is 1 and the bus is idle, an entry with bit 8 (start flag) set is popped. The block then issues phy_cmd 0 (start), followed by phy_cmd 2 (write) carrying bits 7:0 of the entry. Each command is held steady until phy_done.
- R3: When enable is 0 and the bus is idle, no entry is popped and no command is issued.
- R4: When the bus is idle, an entry with bit 8 clear is popped and dropped. It raises tx_err for one cycle and issues no command.
- R5: An entry with bit 9 (stop flag) set is followed by phy_cmd 1 (stop) once its byte completes. When the stop completes, bus_idle_evt pulses for one cycle and bus_busy falls.
- R6: An entry with both bit 8 and bit 9 set gives an address-only transfer: start, write of the address, then stop.
- R7: An address byte with bit 0 equal to 1 is a read. The next entry's bits 7:0 give the byte count N. The block issues N phy_cmd 3 (read) commands, with phy_mack=1 on all of them except the last, which has phy_mack=0. Each byte read is pushed on rx_push/rx_data, in order.
- R8: Completing the final byte of a read raises tx_err for one cycle. Bit 9 of the count entry requests a stop afterwards.
- R9: A phy_nack on an address byte raises tx_err and is followed by a stop.
- R10: A phy_nack on a write byte raises tx_err and is followed by a stop. Queue entries are then discarded up to and including the next one with bit 9 set. The entry after that is handled normally.
- R11: An entry with bit 8 set that arrives while the bus is held issues a repeated start, with no stop before it.
- R12: bus_busy is 1 whenever a command is requested, and stays 1 from the start until the stop completes.
- R13: A read count of 0 issues no read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Device enable; gates new transfers from idle |
| tx_empty | input | 1 | Transmit queue has no entry |
| tx_data | input | BYTE_W+2 | Head entry: byte, bit 8 start flag, bit 9 stop flag |
| tx_pop | output | 1 | Consume the head entry |
| phy_req | output | 1 | Command request to bus engine |
| phy_cmd | output | 2 | 0 start, 1 stop, 2 write, 3 read |
| phy_wdata | output | BYTE_W | Byte to write |
| phy_mack | output | 1 | 1 = master acknowledges the byte read |
| phy_done | input | 1 | Command complete pulse |
| phy_nack | input | 1 | Slave refused the written byte (valid with phy_done) |
| phy_rdata | input | BYTE_W | Byte read (valid with phy_done) |
| rx_push | output | 1 | Received byte strobe |
| rx_data | output | BYTE_W | Received byte |
| tx_err | output | 1 | Error pulse: refused byte, or end of read |
| bus_idle_evt | output | 1 | Pulse when a stop completes |
| bus_busy | output | 1 | Bus held by this master |

## Verification
The bench builds the block with its default width, BYTE_W of 8. This gives 8-bit addresses and data, and read counts up to 255. A single queue stream walks through every path: a dropped headless entry, write runs, an address-only transfer, a three-byte read, a repeated start into a zero-length read, an address refusal and a data refusal. Each refusal is followed by discarded leftovers. The bus engine model completes every command after a short delay. It refuses two chosen byte values, so the error and flush paths are reached from the same stream.

// File: rtl/tw_cmd_seq.sv
module tw_cmd_seq #(
  parameter int BYTE_W = 8,
  localparam int ENT_W = BYTE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tx_empty,
  input  logic [ENT_W-1:0]  tx_data,
  output logic              tx_pop,
  output logic              phy_req,
  output logic [1:0]        phy_cmd,
  output logic [BYTE_W-1:0] phy_wdata,
  output logic              phy_mack,
  input  logic              phy_done,
  input  logic              phy_nack,
  input  logic [BYTE_W-1:0] phy_rdata,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  output logic              tx_err,
  output logic              bus_idle_evt,
  output logic              bus_busy
);
  localparam int START_B = BYTE_W;
  localparam int STOP_B  = BYTE_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_START, S_ADDR, S_WR, S_CNT, S_RD, S_STOP, S_FLUSH
  } st_t;

  st_t               st;
  logic [ENT_W-1:0]  ent;
  logic [BYTE_W-1:0] left;
  logic              stop_after, flush_pend;
  logic              fetch, done, last_rd;

  assign fetch   = (st == S_IDLE) ? enable
                 : (st == S_HOLD || st == S_CNT || st == S_FLUSH);
  assign tx_pop  = fetch && !tx_empty;
  assign phy_req = (st == S_START) || (st == S_ADDR) || (st == S_WR)
                || (st == S_RD) || (st == S_STOP);
  assign done    = phy_req && phy_done;
  assign last_rd = (left == BYTE_W'(1));
  assign phy_wdata = (st == S_ADDR || st == S_WR) ? ent[BYTE_W-1:0] : '0;
  assign phy_mack  = (st == S_RD) && !last_rd;
  assign bus_busy  = !(st == S_IDLE || st == S_FLUSH);

  always_comb begin
    case (st)
      S_STOP:        phy_cmd = 2'd1;
      S_ADDR, S_WR:  phy_cmd = 2'd2;
      S_RD:          phy_cmd = 2'd3;
      default:       phy_cmd = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ent          <= '0;
      left         <= '0;
      stop_after   <= 1'b0;
      flush_pend   <= 1'b0;
      rx_push      <= 1'b0;
      rx_data      <= '0;
      tx_err       <= 1'b0;
      bus_idle_evt <= 1'b0;
    end else begin
      rx_push      <= 1'b0;
      tx_err       <= 1'b0;
      bus_idle_evt <= 1'b0;
      case (st)
        S_IDLE: if (tx_pop) begin
          if (tx_data[START_B]) begin
            ent <= tx_data;
            st  <= S_START;
          end else begin
            tx_err <= 1'b1;
          end
        end
        S_HOLD: if (tx_pop) begin
          ent <= tx_data;
          st  <= tx_data[START_B] ? S_START : S_WR;
        end
        S_START: if (done) st <= S_ADDR;
        S_ADDR, S_WR: if (done) begin
          if (phy_nack) begin
            tx_err     <= 1'b1;
            flush_pend <= !ent[STOP_B];
            st         <= S_STOP;
          end else if (st == S_ADDR && ent[0]) begin
            st <= S_CNT;
          end else begin
            st <= ent[STOP_B] ? S_STOP : S_HOLD;
          end
        end
        S_CNT: if (tx_pop) begin
          left       <= tx_data[BYTE_W-1:0];
          stop_after <= tx_data[STOP_B];
          if (tx_data[BYTE_W-1:0] == '0)
            st <= tx_data[STOP_B] ? S_STOP : S_HOLD;
          else
            st <= S_RD;
        end
        S_RD: if (done) begin
          rx_push <= 1'b1;
          rx_data <= phy_rdata;
          left    <= left - BYTE_W'(1);
          if (last_rd) begin
            tx_err <= 1'b1;
            st     <= stop_after ? S_STOP : S_HOLD;
          end
        end
        S_STOP: if (done) begin
          bus_idle_evt <= 1'b1;
          flush_pend   <= 1'b0;
          st           <= flush_pend ? S_FLUSH : S_IDLE;
        end
        S_FLUSH: if (tx_pop && tx_data[STOP_B]) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_cmd_seq_chk.sv
module tw_cmd_seq_chk #(
  parameter int BYTE_W = 8,
  localparam int ENT_W = BYTE_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_empty,
  input logic              tx_pop,
  input logic              phy_req,
  input logic [1:0]        phy_cmd,
  input logic [BYTE_W-1:0] phy_wdata,
  input logic              phy_mack,
  input logic              phy_done,
  input logic              rx_push,
  input logic              tx_err,
  input logic              bus_idle_evt,
  input logic              bus_busy
);
  assert_hold_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_done |=> phy_req && $stable(phy_cmd) && $stable(phy_wdata));

  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  assert_busy_with_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> bus_busy);

  assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_cmd == 2'd1 && phy_done |=> bus_idle_evt && !bus_busy);

  assert_read_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_cmd == 2'd3 && phy_done |=> rx_push);

  assert_last_read_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_cmd == 2'd3 && phy_done && !phy_mack |=> tx_err);
endmodule

bind tw_cmd_seq tw_cmd_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_pop(tx_pop),
  .phy_req(phy_req), .phy_cmd(phy_cmd), .phy_wdata(phy_wdata),
  .phy_mack(phy_mack), .phy_done(phy_done), .rx_push(rx_push),
  .tx_err(tx_err), .bus_idle_evt(bus_idle_evt), .bus_busy(bus_busy)
);

// File: tb/sim_tw_cmd_seq.sv
module sim_tw_cmd_seq;
  localparam int CLK_P = 10;
  localparam int NS = 17;
  localparam int NE = 29;
  // entry = {stop, start, byte}
  localparam logic [9:0] STREAM [NS] = '{
    10'h055,                   // R4 headless entry in idle: dropped
    10'h1A4, 10'h011, 10'h222, // R2 R5 write run then stop
    10'h350,                   // R6 address only
    10'h1A5, 10'h203,          // R7 R8 read three bytes, stop
    10'h130, 10'h131, 10'h200, // R11 repeated start, R13 zero count
    10'h1E4, 10'h077, 10'h278, // R9 address refused, R10 leftovers dropped
    10'h140, 10'h0BD, 10'h299, // R10 data refused, leftover dropped
    10'h342                    // R10 next entry handled normally
  };
  // log = {cmd, mack, wdata}
  localparam logic [10:0] EXP [NE] = '{
    11'h000, 11'h4A4, 11'h411, 11'h422, 11'h200,   // R2 R5
    11'h000, 11'h450, 11'h200,                     // R6
    11'h000, 11'h4A5, 11'h700, 11'h700, 11'h600, 11'h200, // R7 R8
    11'h000, 11'h430, 11'h000, 11'h431, 11'h200,   // R11 R13
    11'h000, 11'h4E4, 11'h200,                     // R9
    11'h000, 11'h440, 11'h4BD, 11'h200,            // R10
    11'h000, 11'h442, 11'h200                      // R10
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic tx_empty, tx_pop;
  logic [9:0] tx_data;
  logic phy_req, phy_mack, phy_done, phy_nack;
  logic [1:0] phy_cmd;
  logic [7:0] phy_wdata, phy_rdata, rx_data;
  logic rx_push, tx_err, bus_idle_evt, bus_busy;

  int rp, wcnt, rcnt, lc, rc, nerr, nidle, early, bviol, nchk, nfail;
  logic [10:0] lg [64];
  logic [7:0]  rxv [16];

  always #(CLK_P/2) clk = ~clk;

  tw_cmd_seq u0 (.*);

  assign tx_empty = rp >= NS;
  assign tx_data  = tx_empty ? 10'h0 : STREAM[rp];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) rp <= 0;
    else if (tx_pop) rp <= rp + 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_done <= 0; phy_nack <= 0; phy_rdata <= 0; wcnt <= 0; rcnt <= 0;
    end else if (phy_done) begin
      phy_done <= 0;
    end else if (phy_req) begin
      if (wcnt == 1) begin
        wcnt      <= 0;
        phy_done  <= 1;
        phy_nack  <= (phy_cmd == 2'd2) && (phy_wdata == 8'hE4 || phy_wdata == 8'hBD);
        phy_rdata <= 8'hA0 + 8'(rcnt);
        if (phy_cmd == 2'd3) rcnt <= rcnt + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (phy_req && phy_done && lc < 64) begin
      lg[lc] = {phy_cmd, phy_mack, phy_wdata}; lc++;
    end
    if (rx_push && rc < 16) begin rxv[rc] = rx_data; rc++; end
    if (tx_err) begin nerr++; if (lc == 0) early++; end
    if (bus_idle_evt) nidle++;
    if (phy_req && !bus_busy) bviol++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk(!phy_req && !bus_busy && !tx_err && !bus_idle_evt && !rx_push, "R1 reset outputs",
        {phy_req, bus_busy, tx_err, bus_idle_evt, rx_push}, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(rp == 0, "R3 no pop while disabled", rp, 0);
    chk(lc == 0 && !phy_req, "R3 no command while disabled", lc, 0);
    enable = 1;
    cyc = 0;
    while (!(lc >= NE && rp >= NS && !bus_busy) && cyc < 5000) begin
      @(negedge clk); cyc++;
    end
    chk(cyc < 5000, "watchdog", cyc, 5000);
    repeat (5) @(negedge clk);
    chk(early == 1, "R4 headless entry raises error before any command", early, 1);
    chk(lc == NE, "R2 command count", lc, NE);
    for (int i = 0; i < NE; i++)
      chk(lg[i] === EXP[i], $sformatf("command log entry %0d", i), int'(lg[i]), int'(EXP[i]));
    chk(rc == 3, "R7 received byte count", rc, 3);
    for (int i = 0; i < 3; i++)
      chk(rxv[i] === 8'hA0 + 8'(i), "R7 received byte order", int'(rxv[i]), 'hA0 + i);
    chk(nerr == 4, "R8 R9 R10 error pulse count", nerr, 4);
    chk(nidle == 7, "R5 idle pulse count", nidle, 7);
    chk(bviol == 0, "R12 busy during request", bviol, 0);
    chk(!bus_busy && rp == NS, "R10 queue drained, bus released", rp, NS);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule